// File: doc/BRIEF.md
# Page-Entry Cache Range Invalidation Engine

This block owns the invalidate command register of a small cache that holds translated page-table entries. Software writes one 64-bit word that carries an entry count, the real address of the first page-table entry, and a busy flag. If the busy flag is set, the block walks the cache one line per clock. It clears every valid line whose tag falls inside the requested entry range. Busy stays high during the walk, and software polls it before issuing the next command. Ranges longer than one command allows are split by software into successive commands.

The cache is modelled as a parameterised array of tagged lines. A line's tag is the entry's real address divided by eight, which is bits 41:3 of the address. A simple fill port loads lines so that the cache can be populated. Refill policy and the translation walk belong to other blocks.

The control is a two-state machine. `ST_IDLE` accepts register writes and fills. A write with bit 0 set takes the *launch* transition to `ST_SWEEP`. `ST_SWEEP` inspects one line per clock. After the last line it takes the *finish* transition back to `ST_IDLE`. Every other case holds the current state.

Top module: `pte_inv_engine`

## Requirements
- R1: After reset the register reads as all zeros and every cache line is invalid.
- R2: The command word uses three fields. Bits 63:53 hold an 11-bit entry count. Bits 41:3 hold the starting entry address, which is the line tag. Bit 0 is busy. A write in `ST_IDLE` with bit 0 = 1 starts a sweep, and the next read shows bit 0 = 1.
- R3: A sweep keeps busy high for exactly LINES clock cycles after the write edge, inspecting one line per clock, and then clears busy.
- R4: A sweep clears every valid line whose tag T satisfies start <= T < start + count. All other lines keep their valid state.
- R5: A count field of 0 means 2048 entries.
- R6: A register write while busy reads 1 is ignored. The readback does not change, and the running sweep keeps using its original range.
- R7: A read returns the last accepted command word, with bit 0 replaced by the current busy state.
- R8: A write in `ST_IDLE` with bit 0 = 0 stores the word but starts no sweep. The cache lines stay unchanged.
- R9: A fill in `ST_IDLE` makes the addressed line valid with the given tag. A fill while busy is ignored. No line becomes valid without a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Register write strobe |
| cmd_wdata | input | 64 | Register write data |
| cmd_rdata | output | 64 | Register readback, with bit 0 showing busy |
| fill_en | input | 1 | Line fill strobe |
| fill_idx | input | IDX_W | Line index to fill |
| fill_tag | input | 39 | Entry address bits 41:3 for the filled line |
| line_valid | output | LINES | Valid bit of each cache line |

## Verification
The assertions check several behaviours on every cycle:
- a write during busy leaves the readback untouched;
- a launching write raises busy on the next cycle;
- no line turns valid without a fill;
- an idle cycle with no fill leaves the valid bits alone;
- a sweep never outlasts LINES cycles.

Only the bench's scenarios can show which lines a sweep actually clears. These scenarios include the exact range edges, the count-zero case meaning 2048 entries, and a sweep that keeps its original range after a rejected write. The bench also measures the exact cycle in which busy drops.

// File: rtl/pte_inv_pkg.sv
package pte_inv_pkg;
    localparam int CMD_W    = 64;
    localparam int CNT_W    = 11;
    localparam int CNT_LSB  = 53;
    localparam int TAG_LSB  = 3;
    localparam int TAG_W    = 39;
    localparam int ECNT_W   = CNT_W + 1;
    localparam int MAX_ENT  = 1 << CNT_W;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } inv_state_e;
endpackage

// File: rtl/pte_inv_cmd.sv
module pte_inv_cmd
    import pte_inv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CMD_W-1:0]  wdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [TAG_W-1:0]  start_tag,
    output logic [ECNT_W-1:0] ent_cnt
);
    logic [CNT_W-1:0] raw_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (load)
            cmd_q <= wdata;
    end

    always_comb begin
        raw_cnt   = cmd_q[CNT_LSB +: CNT_W];
        start_tag = cmd_q[TAG_LSB +: TAG_W];
        ent_cnt   = (raw_cnt == '0) ? ECNT_W'(MAX_ENT) : {1'b0, raw_cnt};
    end
endmodule

// File: rtl/pte_inv_match.sv
module pte_inv_match
    import pte_inv_pkg::*;
(
    input  logic [TAG_W-1:0]  tag,
    input  logic [TAG_W-1:0]  start_tag,
    input  logic [ECNT_W-1:0] ent_cnt,
    output logic              hit
);
    logic [TAG_W:0] lo, hi, t;

    always_comb begin
        t   = {1'b0, tag};
        lo  = {1'b0, start_tag};
        hi  = lo + (TAG_W + 1)'(ent_cnt);
        hit = (t >= lo) && (t < hi);
    end
endmodule

// File: rtl/pte_inv_lines.sv
module pte_inv_lines
    import pte_inv_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            fill_idx,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic                        clr_en,
    input  logic [IDX_W-1:0]            clr_idx,
    output logic [LINES-1:0]            valid_o,
    output logic [LINES-1:0][TAG_W-1:0] tag_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_o[g] <= 1'b0;
                tag_o[g]   <= '0;
            end else if (fill_en && fill_idx == IDX_W'(g)) begin
                valid_o[g] <= 1'b1;
                tag_o[g]   <= fill_tag;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                valid_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pte_inv_engine.sv
module pte_inv_engine
    import pte_inv_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [63:0]      cmd_wdata,
    output logic [63:0]      cmd_rdata,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [38:0]      fill_tag,
    output logic [LINES-1:0] line_valid
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    inv_state_e              state_q, state_d;
    logic [IDX_W-1:0]        idx_q, idx_d;
    logic                    busy, load, launch, fill_ok, clr_en, hit;
    logic [CMD_W-1:0]        cmd_q;
    logic [TAG_W-1:0]        start_tag;
    logic [ECNT_W-1:0]       ent_cnt;
    logic [LINES-1:0][TAG_W-1:0] tags;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        busy    = 1'b0;
        load    = 1'b0;
        launch  = 1'b0;
        fill_ok = 1'b0;
        clr_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load    = cmd_we;
                launch  = cmd_we && cmd_wdata[0];
                fill_ok = fill_en;
                if (launch) begin
                    state_d = ST_SWEEP;
                    idx_d   = '0;
                end
            end
            ST_SWEEP: begin
                busy   = 1'b1;
                clr_en = hit;
                if (idx_q == LAST_IDX) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    pte_inv_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wdata     (cmd_wdata),
        .cmd_q     (cmd_q),
        .start_tag (start_tag),
        .ent_cnt   (ent_cnt)
    );

    pte_inv_lines #(.LINES(LINES), .IDX_W(IDX_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_ok),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .clr_en   (clr_en),
        .clr_idx  (idx_q),
        .valid_o  (line_valid),
        .tag_o    (tags)
    );

    pte_inv_match u_match (
        .tag       (tags[idx_q]),
        .start_tag (start_tag),
        .ent_cnt   (ent_cnt),
        .hit       (hit)
    );

    assign cmd_rdata = {cmd_q[CMD_W-1:1], busy};
endmodule

// File: rtl/pte_inv_checker.sv
module pte_inv_checker #(
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [63:0]      cmd_wdata,
    input logic [63:0]      cmd_rdata,
    input logic             fill_en,
    input logic [LINES-1:0] line_valid
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else if (cmd_rdata[0])
            busy_run <= busy_run + 1;
        else
            busy_run <= '0;
    end

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[0] && cmd_we) |=> $stable(cmd_rdata[63:1])); // R6

    AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[0] && cmd_we && cmd_wdata[0]) |=> cmd_rdata[0]); // R2

    AST_NO_VALID_WITHOUT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> ((line_valid & ~$past(line_valid)) == '0)); // R9

    AST_IDLE_LINES_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_rdata[0] && !fill_en) |=> $stable(line_valid)); // R8

    AST_SWEEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 32'(LINES)); // R3
endmodule

bind pte_inv_engine pte_inv_checker #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .cmd_rdata  (cmd_rdata),
    .fill_en    (fill_en),
    .line_valid (line_valid)
);

// File: tb/tb_pte_inv_engine.sv
module tb_pte_inv_engine;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 16;
    localparam int IDX_W = $clog2(LINES);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_we = 1'b0;
    logic [63:0]      cmd_wdata = '0;
    logic [63:0]      cmd_rdata;
    logic             fill_en = 1'b0;
    logic [IDX_W-1:0] fill_idx = '0;
    logic [38:0]      fill_tag = '0;
    logic [LINES-1:0] line_valid;

    int n_checks = 0;
    int n_fails  = 0;
    logic [LINES-1:0] exp_vld;
    logic [38:0]      exp_tag [LINES];
    logic [63:0]      exp_cmd;
    int unsigned      seed = 32'h5eed_1234;

    always #(CLK_PERIOD/2) clk = ~clk;

    pte_inv_engine #(.LINES(LINES)) dut (.*);

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    function automatic logic [63:0] mk_cmd(logic [10:0] cnt, logic [38:0] st, logic b);
        return {cnt, 11'h0, st, 2'b00, b};
    endfunction

    function automatic logic in_rng(logic [38:0] t, logic [38:0] st, logic [10:0] cnt);
        logic [39:0] hi;
        hi = {1'b0, st} + ((cnt == 0) ? 40'd2048 : {29'd0, cnt});
        return ({1'b0, t} >= {1'b0, st}) && ({1'b0, t} < hi);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_fill(int idx, logic [38:0] t);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = IDX_W'(idx); fill_tag = t;
        @(negedge clk);
        fill_en = 1'b0;
        exp_vld[idx] = 1'b1;
        exp_tag[idx] = t;
    endtask

    task automatic do_write(logic [63:0] w);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // issue launch, check busy timing, apply model, compare lines
    task automatic sweep(logic [10:0] cnt, logic [38:0] st, string req);
        do_write(mk_cmd(cnt, st, 1'b1));
        exp_cmd = mk_cmd(cnt, st, 1'b0);
        chk("R2 busy set", cmd_rdata, exp_cmd | 64'd1);
        repeat (LINES - 1) @(negedge clk);
        chk("R3 busy high at last line", {63'd0, cmd_rdata[0]}, 64'd1);
        @(negedge clk);
        chk("R3 busy cleared", {63'd0, cmd_rdata[0]}, 64'd0);
        for (int i = 0; i < LINES; i++)
            if (exp_vld[i] && in_rng(exp_tag[i], st, cnt)) exp_vld[i] = 1'b0;
        chk(req, {48'd0, line_valid}, {48'd0, exp_vld});
    endtask

    initial begin
        exp_vld = '0;
        for (int i = 0; i < LINES; i++) exp_tag[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 readback", cmd_rdata, 64'd0);
        chk("R1 lines", {48'd0, line_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 fill and R4 exact edges
        do_fill(0, 39'd999);  do_fill(1, 39'd1000); do_fill(2, 39'd1009);
        do_fill(3, 39'd1010); do_fill(4, 39'd5);
        chk("R9 fill sets valid", {48'd0, line_valid}, {48'd0, exp_vld});
        sweep(11'd10, 39'd1000, "R4 range edges");

        // R5 count zero covers 2048 entries
        do_fill(5, 39'd4000 + 39'd2047); do_fill(6, 39'd4000 + 39'd2048);
        do_fill(7, 39'd4000);
        sweep(11'd0, 39'd4000, "R5 count zero");

        // R8 idle write without busy bit: stored, no sweep
        do_fill(8, 39'd77);
        do_write(mk_cmd(11'd5, 39'd77, 1'b0) | 64'h0010_0000_0000_0000);
        chk("R7 readback stored", cmd_rdata, mk_cmd(11'd5, 39'd77, 1'b0) | 64'h0010_0000_0000_0000);
        repeat (3) @(negedge clk);
        chk("R8 lines unchanged", {48'd0, line_valid}, {48'd0, exp_vld});

        // R6 write during busy ignored; R9 fill during busy ignored
        do_fill(9, 39'd300); do_fill(10, 39'd600);
        do_write(mk_cmd(11'd4, 39'd300, 1'b1));
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = mk_cmd(11'd4, 39'd600, 1'b1);
        fill_en = 1'b1; fill_idx = IDX_W'(11); fill_tag = 39'd55;
        @(negedge clk);
        cmd_we = 1'b0; fill_en = 1'b0;
        chk("R6 readback kept", cmd_rdata, mk_cmd(11'd4, 39'd300, 1'b1));
        repeat (LINES) @(negedge clk);
        chk("R7 busy bit clear", cmd_rdata, mk_cmd(11'd4, 39'd300, 1'b0));
        exp_vld[9] = 1'b0;
        chk("R6 original range used", {48'd0, line_valid}, {48'd0, exp_vld});

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [38:0] st;
            logic [10:0] cnt;
            st  = 39'($urandom(seed) % 100000) + 39'd3000;
            seed = seed + 1;
            cnt = 11'($urandom % 24);
            for (int j = 0; j < 4; j++) begin
                int off;
                off = int'($urandom % 32) - 4;
                do_fill(int'($urandom % LINES), 39'(st + 39'(off)));
            end
            sweep(cnt, st, "R4 random range");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule